// File: doc/BRIEF.md
# Serial Configuration Register Bank Target

This block is a two-wire serial bus target that lets a bus host read and change sixteen 8-bit configuration registers. A transfer opens with a START condition, a 7-bit device address and a direction bit. On a write, the first byte after the address sets an internal register pointer, and each later byte lands in the register that pointer selects. On a read, the host first sets the pointer with a short write. It then issues a repeated START and resends the address with the direction bit high. The target then shifts register contents out, most significant bit first.

The pointer moves forward by one after every data byte in either direction and wraps from 15 to 0. A write lands in its register in the same clock edge that starts driving its acknowledge, so registers settle one by one during a burst rather than at STOP. SCL and SDA are sampled by the system clock through a two-flop synchronizer. SDA is driven only as an active-low enable, and all sixteen registers appear on a flat parallel output bus for the logic they configure.

Top module: `i2c_regbank_target`

## Requirements
- R1: After synchronous reset, the pointer is 0, SDA is released, and register i holds ((17*i) mod 256) XOR 0xA5. Register i appears on regs_o[8*i+7:8*i].
- R2: The target acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 0x5A). On a mismatch it acknowledges nothing and changes no register until the next START or STOP.
- R3: With the direction bit 0 (write), the next byte is acknowledged and its low four bits become the pointer. Its upper four bits are ignored.
- R4: A data byte is written into the register at the pointer no later than the clock edge that begins its acknowledge, so the new value is already visible during the acknowledge clock. Registers change at no other time.
- R5: After each written byte the pointer advances by one and wraps from 15 to 0.
- R6: After a repeated START, an address byte with the direction bit 1 is acknowledged, and the register at the retained pointer is sent MSB first.
- R7: When the host acknowledges a read byte, the next register (pointer plus one, modulo 16) is sent. Sixteen reads return to the start register.
- R8: A host not-acknowledge ends the read with SDA released. After STOP, SDA is released and the next transfer is served normally.
- R9: A STOP or a repeated START that arrives before all eight bits of a data byte leaves every register unchanged. The earlier complete bytes of that transfer stay written, and the pointer stays where it was.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (resolved wired-AND value) |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| regs_o | output | 128 | All sixteen registers, register i in bits 8*i+7 to 8*i |

## Verification
The hardest state to reach from the pins is a bus condition that lands partway through a data byte. At that point several bits sit in the shift register and a full earlier byte has already been written. The bench reaches it with a bit-level host that can stop after any number of bits and then issue STOP or a repeated START. It then checks the register outputs and reads back through the retained pointer to show that nothing moved. Commit timing is observed by snapshotting the register bus in the middle of each acknowledge clock. Pointer wrap is covered by bursts that start near register 15, and by a full 16-byte read.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int REG_COUNT = 16;
    localparam int DATA_W    = 8;
    localparam int PTR_W     = $clog2(REG_COUNT);
    localparam int CNT_W     = $clog2(DATA_W);
    localparam int ADDR_W    = 7;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic byte_t reg_default(input int idx);
        return byte_t'(idx * 17) ^ byte_t'(8'hA5);
    endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync
    import i2c_rb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    localparam int STAGES = 2;

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev_o.scl      = scl_ff[STAGES-1];
        ev_o.sda      = sda_ff[STAGES-1];
        ev_o.scl_rise = scl_ff[STAGES-1] & ~scl_q;
        ev_o.scl_fall = ~scl_ff[STAGES-1] & scl_q;
        ev_o.start    = scl_ff[STAGES-1] & scl_q & sda_q & ~sda_ff[STAGES-1];
        ev_o.stop     = scl_ff[STAGES-1] & scl_q & ~sda_q & sda_ff[STAGES-1];
    end

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile
    import i2c_rb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  ptr_t                        wr_idx,
    input  byte_t                       wr_data,
    input  ptr_t                        rd_idx,
    output byte_t                       rd_data,
    output logic [REG_COUNT*DATA_W-1:0] flat_o
);

    byte_t cells [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= reg_default(g);
            end else if (wr_en && (wr_idx == ptr_t'(g))) begin
                cells[g] <= wr_data;
            end
        end
        assign flat_o[g*DATA_W +: DATA_W] = cells[g];
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h5A
)(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   rd_data,
    output logic    wr_en,
    output byte_t   wr_data,
    output ptr_t    ptr,
    output logic    ptr_load,
    output logic    sda_oe
);

    localparam bitcnt_t LAST_BIT = bitcnt_t'(DATA_W - 1);

    phase_e  phase;
    bitcnt_t cnt;
    logic    full;
    byte_t   shreg;
    byte_t   tx;
    logic    rw;
    logic    host_ack;

    assign wr_en    = (phase == ST_WR)  && ev.scl_fall && full;
    assign ptr_load = (phase == ST_PTR) && ev.scl_fall && full;
    assign wr_data  = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            cnt      <= '0;
            full     <= 1'b0;
            shreg    <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (ev.stop) begin
            phase  <= ST_IDLE;
            sda_oe <= 1'b0;
            cnt    <= '0;
            full   <= 1'b0;
        end else if (ev.start) begin
            phase  <= ST_ADDR;
            sda_oe <= 1'b0;
            cnt    <= '0;
            full   <= 1'b0;
        end else begin
            case (phase)
                ST_ADDR, ST_PTR, ST_WR: begin
                    if (ev.scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) full <= 1'b1;
                    end else if (ev.scl_fall && full) begin
                        full <= 1'b0;
                        cnt  <= '0;
                        case (phase)
                            ST_ADDR: begin
                                if (shreg[DATA_W-1:1] == DEV_ADDR) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    phase  <= ST_ADDR_ACK;
                                end else begin
                                    phase  <= ST_SKIP;
                                end
                            end
                            ST_PTR: begin
                                ptr    <= shreg[PTR_W-1:0];
                                sda_oe <= 1'b1;
                                phase  <= ST_PTR_ACK;
                            end
                            default: begin
                                ptr    <= ptr + 1'b1;
                                sda_oe <= 1'b1;
                                phase  <= ST_WR_ACK;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
                    if (ev.scl_fall) begin
                        if (phase == ST_ADDR_ACK && rw) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            phase  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= (phase == ST_ADDR_ACK) ? ST_PTR : ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (ev.scl_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) full <= 1'b1;
                    end else if (ev.scl_fall) begin
                        if (full) begin
                            full   <= 1'b0;
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                            phase  <= ST_RD_ACK;
                        end else begin
                            sda_oe <= ~tx[LAST_BIT - cnt];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) begin
                        host_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (host_ack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            phase  <= ST_RD;
                        end else begin
                            phase  <= ST_SKIP;
                        end
                    end
                end
                ST_IDLE, ST_SKIP: ;
                default: phase <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h5A
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe_o,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    bus_ev_t ev;
    logic    wr_en;
    byte_t   wr_data;
    byte_t   rd_data;
    ptr_t    ptr;
    logic    ptr_load;

    i2c_rb_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .ptr_load (ptr_load),
        .sda_oe   (sda_oe_o)
    );

    i2c_rb_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .flat_o  (regs_o)
    );

endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker
    import i2c_rb_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        scl_s,
    input logic                        start_s,
    input logic                        stop_s,
    input logic                        sda_oe,
    input logic                        wr_en,
    input ptr_t                        ptr,
    input logic                        ptr_load,
    input logic [REG_COUNT*DATA_W-1:0] regs
);

    // R4: the acknowledge is being driven right after a commit
    assert_ack_follows_commit_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_oe);

    // R4: register contents move only on a commit
    assert_regs_move_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (regs != $past(regs)) |-> $past(wr_en));

    // R5 / R7: pointer either loads or steps by one with wrap
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> ($past(ptr_load) || (ptr == ptr_t'($past(ptr) + 1'b1))));

    // R8: STOP releases the data line
    assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop_s |=> !sda_oe);

    // R10: drive changes only while the synchronized clock line is low
    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        ((sda_oe != $past(sda_oe)) && !$past(start_s) && !$past(stop_s)) |-> !$past(scl_s));

endmodule

bind i2c_regbank_target i2c_rb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (ev.scl),
    .start_s  (ev.start),
    .stop_s   (ev.stop),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .ptr      (ptr),
    .ptr_load (ptr_load),
    .regs     (regs_o)
);

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam logic [6:0] DEV = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_low = 1'b0;
    logic sda_oe;
    logic [127:0] regs;
    wire  sda_bus = !(sda_low || sda_oe);

    int checks = 0;
    int fails  = 0;
    int viol   = 0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_reg [16];
    logic [127:0] ack_snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_target #(.DEV_ADDR(DEV)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // R10 monitor on the raw bus clock
    always @(negedge clk) begin
        if (!rst && (sda_oe != prev_oe) && scl) viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input logic [127:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    task automatic hold();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_low = 1'b0; hold(); scl = 1'b1; hold(); sda_low = 1'b1; hold(); scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_low = 1'b1; hold(); scl = 1'b1; hold(); sda_low = 1'b0; hold(); hold();
    endtask

    task automatic put_bit(input logic b);
        sda_low = !b; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold();
    endtask

    task automatic put_byte(input logic [7:0] d, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        sda_low = 1'b0; hold(); scl = 1'b1; hold();
        acked = !sda_bus;
        ack_snap = regs;
        hold(); scl = 1'b0; hold();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hold(); scl = 1'b1; hold(); d[i] = sda_bus; hold(); scl = 1'b0;
        end
        hold();
        put_bit(!give_ack);
        sda_low = 1'b0;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        put_byte({DEV, 1'b0}, a); check("R2 write address ack", a, 1);
        put_byte(p, a);           check("R3 pointer byte ack", a, 1);
    endtask

    task automatic begin_read();
        logic a;
        bus_start();
        put_byte({DEV, 1'b1}, a); check("R6 read address ack", a, 1);
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < 16; i++) check(req, reg_at(regs, i), exp_reg[i]);
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        logic [3:0] p;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset contents
        for (int i = 0; i < 16; i++) exp_reg[i] = 8'((i * 17) % 256) ^ 8'hA5;
        compare_all("R1 reset value");
        check("R1 SDA released", sda_oe, 0);

        // R2: wrong address ignored
        bus_start();
        put_byte({7'h23, 1'b0}, a); check("R2 mismatch no ack", a, 0);
        put_byte(8'h02, a);         check("R2 ignored byte no ack", a, 0);
        put_byte(8'hEE, a);         check("R2 ignored data no ack", a, 0);
        bus_stop();
        compare_all("R2 registers untouched");

        // R3/R4: random write with upper pointer bits set
        set_ptr(8'h93);
        put_byte(8'h77, a); check("R4 data ack", a, 1);
        check("R4 visible during ack", reg_at(ack_snap, 3), 8'h77);
        bus_stop();
        exp_reg[3] = 8'h77;
        compare_all("R3 only low pointer bits used");

        // R5: sequential write wrapping 15 -> 0
        set_ptr(8'h0C);
        for (int k = 0; k < 8; k++) begin
            p = 4'(12 + k);
            put_byte(8'(8'hC0 + k * 3), a);
            check("R5 burst ack", a, 1);
            check("R4 burst commit at ack", reg_at(ack_snap, int'(p)), 8'(8'hC0 + k * 3));
            exp_reg[p] = 8'(8'hC0 + k * 3);
        end
        bus_stop();
        compare_all("R5 wrap write");

        // R6: random read of every register, sweep over pointer values
        for (int i = 0; i < 16; i++) begin
            set_ptr(8'(i));
            begin_read();
            get_byte(1'b0, d);
            check("R6 random read", d, exp_reg[i]);
            check("R8 released after nack", sda_oe, 0);
            bus_stop();
            check("R8 released after stop", sda_oe, 0);
        end

        // exhaustive write sweep then R7 sequential read of all sixteen from 5
        for (int i = 0; i < 16; i++) begin
            set_ptr(8'(i));
            put_byte(8'((i * 37 + 11) % 256), a);
            check("R4 sweep ack", a, 1);
            bus_stop();
            exp_reg[i] = 8'((i * 37 + 11) % 256);
        end
        compare_all("R4 sweep contents");
        set_ptr(8'h05);
        begin_read();
        for (int k = 0; k < 16; k++) begin
            get_byte(k != 15, d);
            check("R7 sequential read", d, exp_reg[(5 + k) % 16]);
        end
        check("R8 released after final nack", sda_oe, 0);
        bus_stop();

        // R9: STOP mid byte after one full byte
        set_ptr(8'h07);
        put_byte(8'h11, a);
        for (int i = 7; i >= 3; i--) put_bit(i[0]);
        bus_stop();
        exp_reg[7] = 8'h11;
        compare_all("R9 partial byte dropped on stop");

        // R9: repeated START mid byte keeps pointer, then read it
        set_ptr(8'h09);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        begin_read();
        get_byte(1'b1, d);
        check("R9 pointer kept after restart", d, exp_reg[9]);
        get_byte(1'b0, d);
        check("R7 next after restart", d, exp_reg[10]);
        bus_stop();
        compare_all("R9 partial byte dropped on restart");

        // R8: transfer after a NACK-ended read is served normally
        set_ptr(8'h0F);
        put_byte(8'h5C, a);
        put_byte(8'h6D, a); check("R8 following transfer ack", a, 1);
        bus_stop();
        exp_reg[15] = 8'h5C; exp_reg[0] = 8'h6D;
        compare_all("R8 following transfer contents");

        check("R10 SDA changes while SCL high", viol, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule